// File: doc/BRIEF.md
# PC Card Configuration Register File

This block holds the byte-wide configuration registers that a removable storage card exposes in its attribute address space. It also produces the card's single interrupt line to the host. A host bus delivers 8-bit reads and writes. Addresses below a configurable register base fetch bytes from a small read-only card-information table, which is given as a parameter. Addresses at or above the base reach four registers at even offsets: option, status, pin replacement and socket/copy.

The disk core beside the block provides a level interrupt that is mirrored into the status register. The task-file side provides writes of two device-control bits: an interrupt mask and a software reset. The interrupt line to the host depends on the pending bit, both device-control bits and the soft-reset bit of the option register.

A write to the option register with its top bit set resets the whole card. The block clears all of its state and gives the rest of the card a one-cycle reset pulse.

Top module: `pcc_cfg_regfile`

## Requirements
- R1: A read at an address below `REG_BASE` returns table byte number `addr` (bits `8*addr+7:8*addr` of `INFO_BYTES`) when `addr < INFO_LEN`, and returns 0x00 otherwise.
- R2: Reads at any offset from `REG_BASE` other than 0, 2 and 4 return 0x00. This includes the socket/copy register at offset 6. Writes there, and writes below `REG_BASE`, change no register.
- R3: A write to offset 0 (option) without bit 7 set stores the written byte ANDed with 0xCF. A read of offset 0 returns the stored byte.
- R4: A write to offset 0 with bit 7 set clears option, status, both pin bits and both device-control bits at that clock edge. It also raises `card_rst` for exactly the following cycle.
- R5: A write to offset 2 (status) keeps stored bits 7 and 1 and loads bits 6, 5, 4 and 2 from the written byte. Bits 3 and 0 stay 0.
- R6: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the card-ready pin bit. A status write that leaves bit 2 unchanged does not set it. Only reset clears the card-ready bit.
- R7: A read of offset 2 returns the stored status. When the device-control interrupt-mask bit is set, bit 1 reads as 0.
- R8: A read of offset 4 returns 0x0C ORed with the card-ready bit in bit 5. A write to offset 4 loads only written bit 1, which appears on `pin_mready`, and leaves the card-ready bit unchanged.
- R9: Status bit 1 takes the value of `core_irq` at every rising clock edge, except at an edge where a soft reset is written.
- R10: `host_irq` is 1 exactly when status bit 1 is 0, both device-control bits are 0 and option bit 7 is 0.
- R11: After `rst_n` is asserted, option and status read 0x00, pin replacement reads 0x0C, `card_rst` is 0 and `host_irq` is 1.
- R12: A cycle with `devctl_wr` high loads `devctl_nien` and `devctl_srst` into the device-control bits. Reset and soft reset clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr_addr | input | ADDR_W | Attribute-space byte address |
| attr_wr | input | 1 | Write strobe for `attr_wdata` at `attr_addr` |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Combinational read data for `attr_addr` |
| core_irq | input | 1 | Level interrupt request from the disk core |
| devctl_wr | input | 1 | Device-control write strobe from the task-file side |
| devctl_nien | input | 1 | Interrupt-mask bit for the device-control write |
| devctl_srst | input | 1 | Software-reset bit for the device-control write |
| host_irq | output | 1 | Interrupt line to the host |
| card_rst | output | 1 | One-cycle card reset pulse after a soft-reset write |
| pin_mready | output | 1 | Ready-replacement bit last written to the pin register |

## Verification
The bench checks the full address range after every phase, so a decoder that aliases odd or out-of-range offsets onto a register, or that reads past the table end, returns a non-zero byte where zero is expected. Status writes are swept over all 256 values with the core interrupt toggling. A design that applies the wrong preserve or load mask, lets the written bit 1 override the core level, or raises card-ready when the power-down bit has not changed gives the wrong status or pin byte. All eight combinations of device-control bits and core level are checked against the interrupt line and the masked status read. A soft reset is issued while the core interrupt is high. A design that keeps the stale pending bit, misses the device-control clear or stretches the reset pulse shows the wrong value in the first or second cycle afterwards.

// File: rtl/pcc_cfg_pkg.sv
package pcc_cfg_pkg;

   // Register offsets from the register base (even byte lanes)
   localparam int OFS_OPTION = 0;
   localparam int OFS_STATUS = 2;
   localparam int OFS_PINS   = 4;
   localparam int OFS_SOCKET = 6;
   localparam int REG_SPAN   = 8;

   // Write-preserve / load masks
   localparam logic [7:0] OPT_STORE_MASK = 8'hCF;
   localparam logic [7:0] STAT_HOLD_MASK = 8'h82;
   localparam logic [7:0] STAT_LOAD_MASK = 8'h74;
   localparam logic [7:0] PINS_READ_BASE = 8'h0C;

   // Bit positions that other logic decodes
   localparam int OPT_SRST_BIT  = 7;
   localparam int STAT_PEND_BIT = 1;
   localparam int STAT_PWR_BIT  = 2;
   localparam int PINS_RDY_BIT  = 5;
   localparam int PINS_MRDY_BIT = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_INFO,
      SEL_OPTION,
      SEL_STATUS,
      SEL_PINS,
      SEL_SOCKET
   } reg_sel_e;

endpackage

// File: rtl/pcc_info_rom.sv
module pcc_info_rom #(
   parameter int                      ADDR_W     = 10,
   parameter int                      INFO_LEN   = 4,
   parameter logic [8*INFO_LEN-1:0]   INFO_BYTES = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [7:0]        data
);

   logic [7:0] hit_byte [INFO_LEN];

   // One compare-and-gate lane per table byte, OR-reduced below
   for (genvar i = 0; i < INFO_LEN; i++) begin : g_lane
      assign hit_byte[i] = (addr == ADDR_W'(i)) ? INFO_BYTES[8*i +: 8] : 8'h00;
   end

   always_comb begin
      data = 8'h00;
      for (int i = 0; i < INFO_LEN; i++) begin
         data = data | hit_byte[i];
      end
   end

endmodule

// File: rtl/pcc_addr_decode.sv
module pcc_addr_decode
   import pcc_cfg_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int REG_BASE = 'h200
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);

   logic [ADDR_W-1:0] ofs;

   assign ofs = addr - BASE_A;

   always_comb begin
      if (addr < BASE_A) begin
         sel = SEL_INFO;
      end else if (ofs == ADDR_W'(OFS_OPTION)) begin
         sel = SEL_OPTION;
      end else if (ofs == ADDR_W'(OFS_STATUS)) begin
         sel = SEL_STATUS;
      end else if (ofs == ADDR_W'(OFS_PINS)) begin
         sel = SEL_PINS;
      end else if (ofs == ADDR_W'(OFS_SOCKET)) begin
         sel = SEL_SOCKET;
      end else begin
         sel = SEL_NONE;
      end
   end

endmodule

// File: rtl/pcc_cfg_regs.sv
module pcc_cfg_regs
   import pcc_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  reg_sel_e   sel,
   input  logic [7:0] wdata,
   input  logic       core_irq,
   input  logic       devctl_wr,
   input  logic       devctl_nien,
   input  logic       devctl_srst,
   output logic [7:0] opt_q,
   output logic [7:0] stat_q,
   output logic       crdy_q,
   output logic       mrdy_q,
   output logic       nien_q,
   output logic       srst_q,
   output logic       card_rst_q
);

   logic       wr_opt, wr_stat, wr_pins, soft_rst;
   logic       pwr_flip;
   logic [7:0] stat_nxt;

   assign wr_opt   = wr && (sel == SEL_OPTION);
   assign wr_stat  = wr && (sel == SEL_STATUS);
   assign wr_pins  = wr && (sel == SEL_PINS);
   assign soft_rst = wr_opt && wdata[OPT_SRST_BIT];
   assign pwr_flip = wr_stat && (wdata[STAT_PWR_BIT] != stat_q[STAT_PWR_BIT]);

   always_comb begin
      stat_nxt = stat_q;
      if (wr_stat) begin
         stat_nxt = (stat_q & STAT_HOLD_MASK) | (wdata & STAT_LOAD_MASK);
      end
      stat_nxt[STAT_PEND_BIT] = core_irq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_q      <= 8'h00;
         stat_q     <= 8'h00;
         crdy_q     <= 1'b0;
         mrdy_q     <= 1'b0;
         nien_q     <= 1'b0;
         srst_q     <= 1'b0;
         card_rst_q <= 1'b0;
      end else if (soft_rst) begin
         opt_q      <= 8'h00;
         stat_q     <= 8'h00;
         crdy_q     <= 1'b0;
         mrdy_q     <= 1'b0;
         nien_q     <= 1'b0;
         srst_q     <= 1'b0;
         card_rst_q <= 1'b1;
      end else begin
         card_rst_q <= 1'b0;
         stat_q     <= stat_nxt;
         if (wr_opt) begin
            opt_q <= wdata & OPT_STORE_MASK;
         end
         if (pwr_flip) begin
            crdy_q <= 1'b1;
         end
         if (wr_pins) begin
            mrdy_q <= wdata[PINS_MRDY_BIT];
         end
         if (devctl_wr) begin
            nien_q <= devctl_nien;
            srst_q <= devctl_srst;
         end
      end
   end

endmodule

// File: rtl/pcc_cfg_regfile.sv
module pcc_cfg_regfile
   import pcc_cfg_pkg::*;
#(
   parameter int                    ADDR_W     = 10,
   parameter int                    REG_BASE   = 'h200,
   parameter int                    INFO_LEN   = 4,
   parameter logic [8*INFO_LEN-1:0] INFO_BYTES = 32'h01DB_0301
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] attr_addr,
   input  logic              attr_wr,
   input  logic [7:0]        attr_wdata,
   output logic [7:0]        attr_rdata,
   input  logic              core_irq,
   input  logic              devctl_wr,
   input  logic              devctl_nien,
   input  logic              devctl_srst,
   output logic              host_irq,
   output logic              card_rst,
   output logic              pin_mready
);

   localparam longint ADDR_SPACE = longint'(1) << ADDR_W;

   // Elaboration-time parameter checks
   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_addr_w
      $error("pcc_cfg_regfile: ADDR_W out of range");
   end
   if (longint'(REG_BASE) + REG_SPAN > ADDR_SPACE) begin : g_bad_base
      $error("pcc_cfg_regfile: register window exceeds address space");
   end
   if (INFO_LEN < 1 || INFO_LEN > 4096) begin : g_bad_len
      $error("pcc_cfg_regfile: INFO_LEN out of range");
   end

   reg_sel_e   sel;
   logic [7:0] rom_byte;
   logic [7:0] opt_q, stat_q;
   logic       crdy_q, mrdy_q, nien_q, srst_q;

   pcc_addr_decode #(
      .ADDR_W   (ADDR_W),
      .REG_BASE (REG_BASE)
   ) u_dec (
      .addr (attr_addr),
      .sel  (sel)
   );

   pcc_info_rom #(
      .ADDR_W     (ADDR_W),
      .INFO_LEN   (INFO_LEN),
      .INFO_BYTES (INFO_BYTES)
   ) u_rom (
      .addr (attr_addr),
      .data (rom_byte)
   );

   pcc_cfg_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (attr_wr),
      .sel         (sel),
      .wdata       (attr_wdata),
      .core_irq    (core_irq),
      .devctl_wr   (devctl_wr),
      .devctl_nien (devctl_nien),
      .devctl_srst (devctl_srst),
      .opt_q       (opt_q),
      .stat_q      (stat_q),
      .crdy_q      (crdy_q),
      .mrdy_q      (mrdy_q),
      .nien_q      (nien_q),
      .srst_q      (srst_q),
      .card_rst_q  (card_rst)
   );

   always_comb begin
      unique case (sel)
         SEL_INFO:   attr_rdata = rom_byte;
         SEL_OPTION: attr_rdata = opt_q;
         SEL_STATUS: begin
            attr_rdata = stat_q;
            if (nien_q) begin
               attr_rdata[STAT_PEND_BIT] = 1'b0;
            end
         end
         SEL_PINS: begin
            attr_rdata = PINS_READ_BASE;
            attr_rdata[PINS_RDY_BIT] = crdy_q;
         end
         default:    attr_rdata = 8'h00;
      endcase
   end

   assign host_irq   = !stat_q[STAT_PEND_BIT] && !nien_q && !srst_q && !opt_q[OPT_SRST_BIT];
   assign pin_mready = mrdy_q;

endmodule

// File: rtl/pcc_cfg_checker.sv
module pcc_cfg_checker #(
   parameter int ADDR_W   = 10,
   parameter int REG_BASE = 'h200
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] attr_addr,
   input logic              attr_wr,
   input logic [7:0]        attr_wdata,
   input logic [7:0]        attr_rdata,
   input logic              core_irq,
   input logic              host_irq,
   input logic              card_rst,
   input logic [7:0]        opt_q,
   input logic [7:0]        stat_q,
   input logic              crdy_q
);

   localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(REG_BASE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_BASE + 2);
   localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(REG_BASE + 6);

   logic opt_wr, stat_wr, srst_wr;
   assign opt_wr  = attr_wr && attr_addr == A_OPT;
   assign stat_wr = attr_wr && attr_addr == A_STAT;
   assign srst_wr = opt_wr && attr_wdata[7];

   p_opt_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (opt_wr && !attr_wdata[7]) |=> opt_q == ($past(attr_wdata) & 8'hCF));

   p_srst_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      srst_wr |=> (opt_q == 8'h00 && stat_q == 8'h00 && !crdy_q && card_rst));

   p_rst_pulse_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst |-> $past(srst_wr));

   p_stat_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !srst_wr) |=>
         (stat_q & 8'hFD) == (($past(stat_q) & 8'h80) | ($past(attr_wdata) & 8'h74)));

   p_crdy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && attr_wdata[2] != stat_q[2]) |=> crdy_q);

   p_crdy_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (crdy_q && !srst_wr) |=> crdy_q);

   p_pend_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !srst_wr |=> stat_q[1] == $past(core_irq));

   p_irq_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> !stat_q[1]);

   p_sock_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      attr_addr == A_SOCK |-> attr_rdata == 8'h00);

endmodule

bind pcc_cfg_regfile pcc_cfg_checker #(
   .ADDR_W   (ADDR_W),
   .REG_BASE (REG_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .attr_addr  (attr_addr),
   .attr_wr    (attr_wr),
   .attr_wdata (attr_wdata),
   .attr_rdata (attr_rdata),
   .core_irq   (core_irq),
   .host_irq   (host_irq),
   .card_rst   (card_rst),
   .opt_q      (opt_q),
   .stat_q     (stat_q),
   .crdy_q     (crdy_q)
);

// File: tb/tb_pcc_cfg_regfile.sv
`timescale 1ns/1ps
module tb_pcc_cfg_regfile;

   localparam int          AW    = 10;
   localparam int          BASE  = 'h200;
   localparam int          ILEN  = 8;
   localparam logic [63:0] IBYTE = 64'h5A3C_0F81_77E4_2D96;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] attr_addr = '0;
   logic          attr_wr = 1'b0;
   logic [7:0]    attr_wdata = 8'h00;
   logic [7:0]    attr_rdata;
   logic          core_irq = 1'b0;
   logic          devctl_wr = 1'b0;
   logic          devctl_nien = 1'b0;
   logic          devctl_srst = 1'b0;
   logic          host_irq, card_rst, pin_mready;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pcc_cfg_regfile #(
      .ADDR_W(AW), .REG_BASE(BASE), .INFO_LEN(ILEN), .INFO_BYTES(IBYTE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .attr_addr(attr_addr), .attr_wr(attr_wr),
      .attr_wdata(attr_wdata), .attr_rdata(attr_rdata), .core_irq(core_irq),
      .devctl_wr(devctl_wr), .devctl_nien(devctl_nien), .devctl_srst(devctl_srst),
      .host_irq(host_irq), .card_rst(card_rst), .pin_mready(pin_mready)
   );

   // Reference model built from the requirements
   logic [7:0] m_opt = 0, m_stat = 0;
   logic       m_crdy = 0, m_mrdy = 0, m_nien = 0, m_srst = 0, m_crst = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_opt = 0; m_stat = 0; m_crdy = 0; m_mrdy = 0;
         m_nien = 0; m_srst = 0; m_crst = 0;
      end else if (attr_wr && int'(attr_addr) == BASE && attr_wdata[7]) begin
         m_opt = 0; m_stat = 0; m_crdy = 0; m_mrdy = 0;
         m_nien = 0; m_srst = 0; m_crst = 1;
      end else begin
         m_crst = 0;
         if (attr_wr && int'(attr_addr) == BASE) m_opt = attr_wdata & 8'hCF;
         if (attr_wr && int'(attr_addr) == BASE + 2) begin
            if (attr_wdata[2] != m_stat[2]) m_crdy = 1;
            m_stat = (m_stat & 8'h80) | (attr_wdata & 8'h74);
         end
         m_stat[1] = core_irq;
         if (attr_wr && int'(attr_addr) == BASE + 4) m_mrdy = attr_wdata[1];
         if (devctl_wr) begin
            m_nien = devctl_nien;
            m_srst = devctl_srst;
         end
      end
   end

   function automatic logic [7:0] exp_rd(int a);
      if (a < BASE) return (a < ILEN) ? IBYTE[8*a +: 8] : 8'h00;
      case (a - BASE)
         0: return m_opt;
         2: return m_nien ? (m_stat & 8'hFD) : m_stat;
         4: return 8'h0C | {2'b00, m_crdy, 5'b00000};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic exp_irq();
      return !m_stat[1] && !m_nien && !m_srst && !m_opt[7];
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%02h exp=%02h", req, act, exp);
      end
   endtask

   task automatic rd_chk(string req, int a);
      attr_addr = AW'(a);
      #1;
      chk(req, attr_rdata, exp_rd(a));
   endtask

   task automatic sweep();
      for (int a = 0; a < (1 << AW); a++) begin
         @(negedge clk);
         if (a < BASE)            rd_chk("R1", a);
         else if (a == BASE)      rd_chk("R3", a);
         else if (a == BASE + 2)  rd_chk("R7", a);
         else if (a == BASE + 4)  rd_chk("R8", a);
         else                     rd_chk("R2", a);
      end
   endtask

   task automatic do_wr(int a, logic [7:0] d);
      @(negedge clk);
      attr_addr = AW'(a); attr_wdata = d; attr_wr = 1'b1;
      @(negedge clk);
      attr_wr = 1'b0;
   endtask

   task automatic do_dc(logic nien, logic srst);
      @(negedge clk);
      devctl_nien = nien; devctl_srst = srst; devctl_wr = 1'b1;
      @(negedge clk);
      devctl_wr = 1'b0;
   endtask

   task automatic chk_irq(string req);
      chk(req, {7'd0, host_irq}, {7'd0, exp_irq()});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11: reset state
      chk("R11 host_irq", {7'd0, host_irq}, 8'd1);
      chk("R11 card_rst", {7'd0, card_rst}, 8'd0);
      rd_chk("R11 option", BASE);
      rd_chk("R11 status", BASE + 2);
      chk("R11 pins", attr_rdata, 8'h00);
      rd_chk("R11 pins", BASE + 4);
      chk("R11 pins literal", attr_rdata, 8'h0C);
      sweep();

      // R3: option store mask over all values without bit 7
      for (int v = 0; v < 128; v++) begin
         do_wr(BASE, 8'(v));
         rd_chk("R3", BASE);
         chk("R3 literal", attr_rdata, 8'(v) & 8'hCF);
      end

      // R6: unchanged power-down leaves card-ready clear
      do_wr(BASE + 2, 8'h00);
      rd_chk("R6 no flip", BASE + 4);
      chk("R6 no flip literal", attr_rdata, 8'h0C);
      do_wr(BASE + 2, 8'h04);
      rd_chk("R6 flip", BASE + 4);
      chk("R6 flip literal", attr_rdata, 8'h2C);

      // R5/R9: status sweep with the core level toggling
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         core_irq = v[3];
         do_wr(BASE + 2, 8'(v));
         rd_chk("R5", BASE + 2);
         rd_chk("R6", BASE + 4);
         chk_irq("R10");
      end

      // R8: pin register writes
      do_wr(BASE + 4, 8'hFF);
      rd_chk("R8", BASE + 4);
      chk("R8 mready", {7'd0, pin_mready}, 8'd1);
      do_wr(BASE + 4, 8'h00);
      rd_chk("R8", BASE + 4);
      chk("R8 mready", {7'd0, pin_mready}, 8'd0);
      do_wr(BASE + 4, 8'hFD);
      chk("R8 mready", {7'd0, pin_mready}, 8'd0);

      // R7/R10/R12/R9: device-control and core level combinations
      for (int c = 0; c < 8; c++) begin
         do_dc(c[0], c[1]);
         @(negedge clk);
         core_irq = c[2];
         @(negedge clk);
         rd_chk("R7", BASE + 2);
         chk_irq("R10");
         chk("R9 pending", attr_rdata[1], c[0] ? 1'b0 : c[2]);
      end
      do_dc(1'b0, 1'b0);
      @(negedge clk);
      core_irq = 1'b0;
      @(negedge clk);
      chk_irq("R12 cleared mask");

      // R2: writes that must change nothing
      do_wr(BASE + 2, 8'h54);
      do_wr(BASE, 8'h4A);
      do_wr(BASE + 6, 8'hFF);
      do_wr(BASE + 1, 8'hFF);
      do_wr(BASE + 3, 8'hFF);
      do_wr(BASE + 5, 8'hFF);
      do_wr(BASE + 8, 8'hFF);
      do_wr(3, 8'h80);
      do_wr(BASE - 1, 8'hFF);
      rd_chk("R2 option kept", BASE);
      chk("R2 option literal", attr_rdata, 8'h4A);
      rd_chk("R2 status kept", BASE + 2);
      chk("R2 status literal", attr_rdata, 8'h54);
      chk("R2 no reset", {7'd0, card_rst}, 8'd0);
      sweep();

      // R4: soft reset with the core interrupt high
      do_dc(1'b1, 1'b0);
      @(negedge clk);
      core_irq = 1'b1;
      do_wr(BASE, 8'hC3);
      chk("R4 pulse", {7'd0, card_rst}, 8'd1);
      rd_chk("R4 option", BASE);
      rd_chk("R4 status", BASE + 2);
      chk("R4 status literal", attr_rdata, 8'h00);
      rd_chk("R4 pins", BASE + 4);
      chk("R4 pins literal", attr_rdata, 8'h0C);
      chk_irq("R4 irq");
      chk("R4 irq literal", {7'd0, host_irq}, 8'd1);
      @(negedge clk);
      chk("R4 pulse end", {7'd0, card_rst}, 8'd0);
      rd_chk("R9 reload", BASE + 2);
      chk("R9 reload literal", attr_rdata, 8'h02);
      chk_irq("R10 after reset");
      core_irq = 1'b0;
      sweep();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule